// File: doc/BRIEF.md
# Byte-Addressed Word Memory with Selectable Byte Order

This block is a synchronous storage array that holds 32-bit words but is addressed one byte at a time. Each request carries a byte address, a size flag that picks a single byte or a whole word, a write strobe and write data. Every byte address names the next 8-bit location, so word boundaries fall at addresses 0, 4, 8 and so on. A static order input selects how the byte addresses inside a word map onto the four 8-bit lanes of the stored word. In one setting the lowest address names the top lane; in the other it names the bottom lane.

A byte write changes only the lane that its address selects. A word write replaces all four lanes. A byte read returns the selected lane in the low 8 bits of the read data, with the upper bits cleared. Word accesses must sit on a 4-byte boundary. A word request whose two low address bits are not zero does not touch storage, and the block raises an error flag for that request.

Read data is registered, so it appears one cycle after the request. The byte address width is a parameter, and so is the number of stored words. Address bits above the implemented depth are ignored, so addresses that differ only in those bits alias onto the same word.

Top module: `lane_mem`

## Requirements
- R1: After reset, `rdData` is 0 and `alignErr` is 0.
- R2: An aligned word write stores `wrData` unchanged. An aligned word read returns that word on `rdData` in the cycle after the read request.
- R3: With `bigEndian`=0, the byte at offset o (= `reqAddr[1:0]`) inside a word is the lane in bits 8o+7:8o.
- R4: With `bigEndian`=1, the byte at offset o is the lane in bits 31-8o:24-8o. Offset 0 is bits 31:24.
- R5: A byte write puts `wrData[7:0]` into the selected lane and leaves the other three lanes of that word unchanged.
- R6: A byte read returns the selected lane in `rdData[7:0]`, with `rdData[31:8]` equal to 0.
- R7: A word request (read or write) with `reqAddr[1:0]` not equal to 00 sets `alignErr` to 1 in the following cycle only. Such a write changes no stored byte.
- R8: A misaligned word read sets `rdData` to 0 in the following cycle.
- R9: A read does not change the stored contents, so repeated reads of one location return the same value.
- R10: The word index is `reqAddr[IDX_W+1:2]`, with IDX_W = log2(MEM_WORDS). Two addresses that differ only in the higher bits reach the same word.
- R11: A byte request never sets `alignErr`, whatever its offset.
- R12: `rdData` keeps its value in the cycle after an idle cycle or a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | A request is present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = word access, 0 = byte access |
| reqAddr | input | ADDR_W | Byte address |
| wrData | input | 32 | Write data; a byte write uses bits 7:0 |
| bigEndian | input | 1 | Static byte order: 1 = lowest address in top lane |
| rdData | output | 32 | Registered read data |
| alignErr | output | 1 | Misaligned word request seen in the previous cycle |

## Verification
The bench first writes a known word. It then reads single bytes at each offset under both byte orders. A lane mapping that was swapped or left unreversed would return the wrong byte. Byte writes are followed by whole-word reads, which exposes a design that clobbers neighbouring lanes or writes the byte into the wrong lane. Misaligned word writes are followed by aligned reads of the same word, so a write that is flagged but not suppressed shows up as changed data. The aliasing addresses, the holds after idle and write cycles, and a long mixed random stream are all compared against a behavioural model. A wrong wrap, stale read data or a flag that stays high would each show up as a mismatch.

// File: rtl/lane_mem_pkg.sv
package lane_mem_pkg;
  localparam int BYTE_W    = 8;
  localparam int LANES     = 4;
  localparam int WORD_W    = BYTE_W * LANES;
  localparam int LANE_BITS = $clog2(LANES);

  typedef struct packed {
    logic             wrEn;      // storage write this cycle
    logic [LANES-1:0] laneMask;  // lanes written
    logic             wrByte;    // write data comes from low byte
    logic             rdEn;      // load read register with data
    logic             rdClear;   // load read register with zero
    logic             rdByte;    // read returns one lane
    logic [LANE_BITS-1:0] rdLane;
    logic             fault;     // misaligned word request
  } memStrobe_t;
endpackage

// File: rtl/lane_mem_ctrl.sv
module lane_mem_ctrl
  import lane_mem_pkg::*;
(
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic                 reqWord,
  input  logic [LANE_BITS-1:0] offset,
  input  logic                 bigEndian,
  output memStrobe_t           strobe
);
  logic [LANE_BITS-1:0] lane;
  logic                 misaligned;
  logic [LANES-1:0]     maskV;

  assign lane       = bigEndian ? (LANE_BITS'(LANES - 1) - offset) : offset;
  assign misaligned = reqWord && (offset != '0);

  for (genvar l = 0; l < LANES; l++) begin : gMask
    assign maskV[l] = reqWord || (lane == LANE_BITS'(l));
  end

  always_comb begin
    strobe          = '0;
    strobe.fault    = reqValid && misaligned;
    strobe.wrEn     = reqValid && reqWrite && !misaligned;
    strobe.laneMask = maskV;
    strobe.wrByte   = !reqWord;
    strobe.rdEn     = reqValid && !reqWrite && !misaligned;
    strobe.rdClear  = reqValid && !reqWrite && misaligned;
    strobe.rdByte   = !reqWord;
    strobe.rdLane   = lane;
  end
endmodule

// File: rtl/lane_mem_dp.sv
module lane_mem_dp
  import lane_mem_pkg::*;
#(
  parameter int MEM_WORDS = 32,
  localparam int IDX_W    = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [WORD_W-1:0] wrData,
  input  memStrobe_t        strobe,
  output logic [WORD_W-1:0] rdData,
  output logic              alignErr
);
  logic [WORD_W-1:0] rdWord;
  logic [BYTE_W-1:0] rdSel;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic [BYTE_W-1:0] cells [MEM_WORDS];
    logic [BYTE_W-1:0] laneIn;

    assign laneIn = strobe.wrByte ? wrData[BYTE_W-1:0] : wrData[BYTE_W*l +: BYTE_W];

    always_ff @(posedge clk) begin
      if (strobe.wrEn && strobe.laneMask[l]) cells[wordIdx] <= laneIn;
    end

    assign rdWord[BYTE_W*l +: BYTE_W] = cells[wordIdx];
  end

  assign rdSel = rdWord[BYTE_W*strobe.rdLane +: BYTE_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData   <= '0;
      alignErr <= 1'b0;
    end else begin
      alignErr <= strobe.fault;
      if (strobe.rdEn)
        rdData <= strobe.rdByte ? {{(WORD_W-BYTE_W){1'b0}}, rdSel} : rdWord;
      else if (strobe.rdClear)
        rdData <= '0;
    end
  end
endmodule

// File: rtl/lane_mem.sv
module lane_mem
  import lane_mem_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MEM_WORDS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       wrData,
  input  logic              bigEndian,
  output logic [31:0]       rdData,
  output logic              alignErr
);
  localparam int IDX_W = $clog2(MEM_WORDS);

  memStrobe_t       strobe;
  logic [IDX_W-1:0] wordIdx;
  logic             unusedHiBits;

  assign wordIdx      = reqAddr[IDX_W+LANE_BITS-1:LANE_BITS];
  assign unusedHiBits = &{1'b0, reqAddr[ADDR_W-1:IDX_W+LANE_BITS]};

  lane_mem_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqWord  (reqWord),
    .offset   (reqAddr[LANE_BITS-1:0]),
    .bigEndian(bigEndian),
    .strobe   (strobe)
  );

  lane_mem_dp #(.MEM_WORDS(MEM_WORDS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .wordIdx (wordIdx),
    .wrData  (wrData),
    .strobe  (strobe),
    .rdData  (rdData),
    .alignErr(alignErr)
  );
endmodule

// File: rtl/lane_mem_chk.sv
module lane_mem_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              reqWord,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [31:0]       wrData,
  input logic              bigEndian,
  input logic [31:0]       rdData,
  input logic              alignErr
);
  logic badWord;
  logic unusedOrder;
  assign badWord     = reqValid && reqWord && (reqAddr[1:0] != 2'b00);
  assign unusedOrder = bigEndian;

  AST_WORD_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqWord && reqAddr[1:0] == 2'b00 &&
     $past(reqValid && reqWrite && reqWord) && $past(reqAddr) == reqAddr)
    |=> rdData == $past(wrData, 2)); // R2
  AST_BYTE_READ_ZEXT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && !reqWord) |=> rdData[31:8] == 24'd0); // R6
  AST_MISALIGN_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    badWord |=> alignErr); // R7
  AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> $past(badWord)); // R7
  AST_MISALIGN_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (badWord && !reqWrite) |=> rdData == 32'd0); // R8
  AST_BYTE_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWord) |=> !alignErr); // R11
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite) |=> $stable(rdData)); // R12
endmodule

bind lane_mem lane_mem_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_lane_mem.sv
`timescale 1ns/1ps
module test_lane_mem;
  localparam int ADDR_W    = 8;
  localparam int MEM_WORDS = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic              reqWord = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [31:0]       wrData = '0;
  logic              bigEndian = 1'b0;
  logic [31:0]       rdData;
  logic              alignErr;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] model [MEM_WORDS];
  logic [31:0] expRd = '0;
  logic        expErr = 1'b0;

  always #2 clk = ~clk;

  lane_mem #(.ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS)) i_lane_mem (.*);

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one request at a negedge; model predicts; compared at the next negedge
  task automatic req(input logic v, input logic w, input logic wd,
                     input logic [ADDR_W-1:0] a, input logic [31:0] d, input string tag);
    int idx;
    int ln;
    reqValid = v; reqWrite = w; reqWord = wd; reqAddr = a; wrData = d;
    idx = int'(a >> 2) % MEM_WORDS;
    ln  = bigEndian ? 3 - int'(a[1:0]) : int'(a[1:0]);
    expErr = 1'b0;
    if (v) begin
      if (wd && a[1:0] != 2'b00) begin
        expErr = 1'b1;
        if (!w) expRd = '0;
      end else if (w) begin
        if (wd) model[idx] = d;
        else    model[idx][8*ln +: 8] = d[7:0];
      end else begin
        expRd = wd ? model[idx] : {24'd0, model[idx][8*ln +: 8]};
      end
    end
    @(negedge clk);
    reqValid = 1'b0;
    check(rdData, expRd, {tag, " rdData"});
    check({31'd0, alignErr}, {31'd0, expErr}, {tag, " alignErr"});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(rdData, 32'd0, "R1 reset rdData");
    check({31'd0, alignErr}, 32'd0, "R1 reset alignErr");

    for (int i = 0; i < MEM_WORDS; i++)
      req(1, 1, 1, ADDR_W'(4 * i), 32'h5A000000 ^ (i * 32'h01030507), "R2 fill");

    req(1, 1, 1, 8'h10, 32'h11223344, "R2 write");
    req(1, 0, 1, 8'h10, 0, "R2 read");
    check(rdData, 32'h11223344, "R2 literal word");
    req(1, 0, 0, 8'h10, 0, "R3 byte0");
    check(rdData, 32'h00000044, "R3 R6 little offset0");
    req(1, 0, 0, 8'h13, 0, "R3 byte3");
    check(rdData, 32'h00000011, "R3 little offset3");
    req(1, 1, 0, 8'h12, 32'hFFFFFFEE, "R5 byte write");
    req(0, 0, 0, 8'h00, 0, "R12 idle");
    check(rdData, 32'h00000011, "R12 hold after idle");
    req(1, 0, 1, 8'h10, 0, "R5 readback");
    check(rdData, 32'h11EE3344, "R5 other lanes kept");
    req(1, 1, 1, 8'h24, 32'h0BADF00D, "R12 write");
    check(rdData, 32'h11EE3344, "R12 hold after write");

    req(1, 1, 1, 8'h21, 32'hDEADBEEF, "R7 misaligned write");
    check({31'd0, alignErr}, 32'd1, "R7 flag raised");
    req(1, 0, 1, 8'h20, 0, "R7 word unchanged");
    check({31'd0, alignErr}, 32'd0, "R7 flag one cycle");
    req(1, 0, 1, 8'h22, 0, "R8 misaligned read");
    check(rdData, 32'd0, "R8 zero data");
    for (int o = 0; o < 4; o++) req(1, 0, 0, ADDR_W'(8'h10 + o), 0, "R11 byte offsets");

    req(1, 0, 1, 8'h10, 0, "R9 read a");
    req(1, 0, 1, 8'h10, 0, "R9 read b");
    check(rdData, 32'h11EE3344, "R9 unchanged");

    req(1, 1, 1, 8'h88, 32'hCAFEF00D, "R10 high alias write");
    req(1, 0, 1, 8'h08, 0, "R10 low alias read");
    check(rdData, 32'hCAFEF00D, "R10 alias");

    bigEndian = 1'b1;
    req(1, 0, 0, 8'h10, 0, "R4 offset0");
    check(rdData, 32'h00000011, "R4 big offset0");
    req(1, 0, 0, 8'h13, 0, "R4 offset3");
    check(rdData, 32'h00000044, "R4 big offset3");
    req(1, 1, 0, 8'h11, 32'h00000077, "R4 byte write");
    req(1, 0, 1, 8'h10, 0, "R4 R5 readback");
    check(rdData, 32'h11773344, "R4 R5 big lane write");

    for (int n = 0; n < 600; n++) begin
      if (n == 300) bigEndian = 1'b0;
      req(($urandom % 8) != 0, 1'($urandom), 1'($urandom),
          ADDR_W'($urandom), $urandom, "R2 R5 R7 R10 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule